// File: doc/BRIEF.md
# Integer Compare and Set-Predicate Unit

This execution slice compares two 32-bit integer operands under a condition chosen by the instruction word. The comparison is signed or unsigned, as a single instruction bit selects. The comparison result, and separately its inverse, is merged with a source predicate through a selectable logic combiner. The two results go to two 1-bit destinations in an 8-entry predicate file.

Operand A comes straight from the register datapath. Operand B is taken from a register input or from a constant-buffer input, chosen by a select pin. Predicate index 7 is hard-wired true: it always reads 1 and discards every write to it.

The whole predicate file is visible on `pred_o`. Writes land on the clock edge that samples `valid_i`. An instruction that names index 7 as its primary destination is illegal. It writes nothing and raises `err_o` for one cycle.

Top module: `icmp_pred_unit`

## Requirements
- R1: After reset `pred_o` is 8'h80 (entries 0..6 clear, entry 7 set) and `err_o` is 0.
- R2: With instruction bit 48 clear the comparison is unsigned; condition field bits 51:49 encode 1 = A<B, 2 = A==B, 3 = A<=B, 4 = A>B, 5 = A!=B, 6 = A>=B.
- R3: With bit 48 set the same conditions compare A and B as two's-complement signed values.
- R4: Combiner field bits 46:45 selects 0 = AND, 1 = OR, 2 = XOR with the source predicate; 3 passes the comparison term through and ignores the source predicate.
- R5: The source predicate is the entry at index bits 41:39, read before this instruction's writes. Index 7 reads 1. Bit 42 inverts the source predicate before it is combined.
- R6: The primary destination, at index bits 5:3, receives (comparison OP source predicate).
- R7: The secondary destination, at index bits 2:0, receives (inverted comparison OP source predicate). Nothing is written for it when its index is 7.
- R8: When the primary and secondary indices are equal and not 7, the entry takes the secondary value.
- R9: A valid instruction whose primary index is 7 writes no entry, and `err_o` is 1 in the cycle after it. `err_o` is 0 after every other cycle.
- R10: Writes take effect at the rising edge that samples `valid_i` high. Without `valid_i`, `pred_o` holds its value, and bit 7 of `pred_o` is always 1.
- R11: `b_sel_cbuf_i` = 1 takes operand B from `cbuf_b_i`; 0 takes it from `reg_b_i`.
- R12: Condition code 0 gives a false comparison and code 7 a true one, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction valid this cycle |
| instr_i | input | 64 | Decoded instruction word |
| opa_i | input | 32 | Operand A |
| reg_b_i | input | 32 | Operand B from a register |
| cbuf_b_i | input | 32 | Operand B from the constant buffer |
| b_sel_cbuf_i | input | 1 | 1 selects cbuf_b_i as operand B |
| pred_o | output | 8 | Current predicate file contents, bit i = entry i |
| err_o | output | 1 | Illegal primary destination seen last cycle |

## Verification
A wrong entry in the predicate file appears on `pred_o` in the cycle right after the faulty write. The bench checks the full vector, so a stray write to a bystander entry is caught as well. A corrupted entry that is later used as a source predicate is caught a second time: it sends a wrong result into the next destination one instruction later. Signedness, condition and combiner faults are isolated by operand pairs whose signed and unsigned orderings disagree, and by sweeping every combiner against both source values.

// File: rtl/icmp_pkg.sv
package icmp_pkg;
  localparam int unsigned INSTR_W = 64;
  localparam int unsigned PIDX_W  = 3;

  typedef enum logic [2:0] {
    C_FALSE = 3'd0, C_LT = 3'd1, C_EQ = 3'd2, C_LE = 3'd3,
    C_GT = 3'd4, C_NE = 3'd5, C_GE = 3'd6, C_TRUE = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    K_AND = 2'd0, K_OR = 2'd1, K_XOR = 2'd2, K_PASS = 2'd3
  } comb_e;

  typedef struct packed {
    logic [PIDX_W-1:0] pri;
    logic [PIDX_W-1:0] sec;
    logic [PIDX_W-1:0] src;
    logic              src_neg;
    comb_e             comb;
    logic              sgn;
    cond_e             cond;
  } dec_t;

  function automatic dec_t decode(input logic [INSTR_W-1:0] w);
    dec_t d;
    d.sec     = w[2:0];
    d.pri     = w[5:3];
    d.src     = w[41:39];
    d.src_neg = w[42];
    d.comb    = comb_e'(w[46:45]);
    d.sgn     = w[48];
    d.cond    = cond_e'(w[51:49]);
    return d;
  endfunction
endpackage

// File: rtl/icmp_compare.sv
module icmp_compare
  import icmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sgn_i,
  input  cond_e             cond_i,
  output logic              res_o
);
  logic lt, eq;

  always_comb begin
    eq = (a_i == b_i);
    lt = sgn_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
    unique case (cond_i)
      C_FALSE: res_o = 1'b0;
      C_LT:    res_o = lt;
      C_EQ:    res_o = eq;
      C_LE:    res_o = lt | eq;
      C_GT:    res_o = ~(lt | eq);
      C_NE:    res_o = ~eq;
      C_GE:    res_o = ~lt;
      default: res_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pred_combine.sv
module pred_combine
  import icmp_pkg::*;
(
  input  logic  cmp_i,
  input  logic  src_i,
  input  comb_e comb_i,
  output logic  pri_o,
  output logic  sec_o
);
  logic [1:0] term, res;
  assign term = {~cmp_i, cmp_i};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb begin
      unique case (comb_i)
        K_AND:   res[g] = term[g] & src_i;
        K_OR:    res[g] = term[g] | src_i;
        K_XOR:   res[g] = term[g] ^ src_i;
        default: res[g] = term[g];
      endcase
    end
  end

  assign pri_o = res[0];
  assign sec_o = res[1];
endmodule

// File: rtl/pred_file.sv
module pred_file #(
  parameter int unsigned NPRED  = 8,
  localparam int unsigned IDX_W = $clog2(NPRED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we0_i,
  input  logic [IDX_W-1:0] wa0_i,
  input  logic             wd0_i,
  input  logic             we1_i,
  input  logic [IDX_W-1:0] wa1_i,
  input  logic             wd1_i,
  input  logic [IDX_W-1:0] ra_i,
  output logic             rd_o,
  output logic [NPRED-1:0] all_o
);
  for (genvar i = 0; i < NPRED; i++) begin : g_ent
    if (i == NPRED - 1) begin : g_true
      assign all_o[i] = 1'b1;
    end else begin : g_reg
      logic q;
      // port 1 (secondary) has priority on a shared index
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= 1'b0;
        else if (we1_i && wa1_i == IDX_W'(i))     q <= wd1_i;
        else if (we0_i && wa0_i == IDX_W'(i))     q <= wd0_i;
      end
      assign all_o[i] = q;
    end
  end

  assign rd_o = all_o[ra_i];
endmodule

// File: rtl/icmp_pred_unit.sv
module icmp_pred_unit
  import icmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NPRED  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  reg_b_i,
  input  logic [DATA_W-1:0]  cbuf_b_i,
  input  logic               b_sel_cbuf_i,
  output logic [NPRED-1:0]   pred_o,
  output logic               err_o
);
  localparam logic [PIDX_W-1:0] TRUE_IDX = PIDX_W'(NPRED - 1);

  dec_t              dec;
  logic [DATA_W-1:0] opb;
  logic              cmp, src_raw, src_p, pri_v, sec_v;
  logic              illegal, we_pri, we_sec, err_q;

  assign dec     = decode(instr_i);
  assign opb     = b_sel_cbuf_i ? cbuf_b_i : reg_b_i;
  assign src_p   = src_raw ^ dec.src_neg;
  assign illegal = valid_i && (dec.pri == TRUE_IDX);
  assign we_pri  = valid_i && !illegal;
  assign we_sec  = we_pri && (dec.sec != TRUE_IDX);

  icmp_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_i(opa_i), .b_i(opb), .sgn_i(dec.sgn), .cond_i(dec.cond), .res_o(cmp)
  );

  pred_combine u_comb (
    .cmp_i(cmp), .src_i(src_p), .comb_i(dec.comb), .pri_o(pri_v), .sec_o(sec_v)
  );

  pred_file #(.NPRED(NPRED)) u_pf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we0_i(we_pri), .wa0_i(dec.pri), .wd0_i(pri_v),
    .we1_i(we_sec), .wa1_i(dec.sec), .wd1_i(sec_v),
    .ra_i(dec.src), .rd_o(src_raw), .all_o(pred_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= illegal;
  end
  assign err_o = err_q;
endmodule

// File: rtl/icmp_pred_chk.sv
module icmp_pred_chk #(
  parameter int unsigned NPRED = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [63:0]      instr_i,
  input logic [NPRED-1:0] pred_o,
  input logic             err_o
);
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pred_o));

  p_top_true_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_o[NPRED-1]);

  p_illegal_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[5:3] == 3'd7) |=> (err_o && $stable(pred_o)));

  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && instr_i[5:3] == 3'd7) |=> !err_o);

  p_two_writes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($countones(pred_o ^ $past(pred_o)) <= 2));

  p_nosec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[2:0] == 3'd7) |=> ($countones(pred_o ^ $past(pred_o)) <= 1));
endmodule

bind icmp_pred_unit icmp_pred_chk #(.NPRED(NPRED)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
  .pred_o(pred_o), .err_o(err_o)
);

// File: tb/sim_icmp_pred_unit.sv
`timescale 1ns/1ps
module sim_icmp_pred_unit;
  logic        clk = 1'b0, rst_ni = 1'b0, valid = 1'b0, bsel = 1'b0;
  logic [63:0] instr = '0;
  logic [31:0] opa = '0, regb = '0, cbufb = '0;
  logic [7:0]  pred;
  logic        err;
  logic [6:0]  e = '0;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  icmp_pred_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .instr_i(instr),
    .opa_i(opa), .reg_b_i(regb), .cbuf_b_i(cbufb), .b_sel_cbuf_i(bsel),
    .pred_o(pred), .err_o(err)
  );

  function automatic logic [63:0] mk(int pri, int sec, int src, bit neg,
                                     int comb, bit sgn, int cond);
    logic [63:0] w = '0;
    w[2:0] = 3'(sec); w[5:3] = 3'(pri); w[41:39] = 3'(src); w[42] = neg;
    w[46:45] = 2'(comb); w[48] = sgn; w[51:49] = 3'(cond);
    return w;
  endfunction

  function automatic bit cmpf(int cond, bit sgn, logic [31:0] a, logic [31:0] b);
    bit lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    bit eq = (a == b);
    case (cond)
      1: return lt;       2: return eq;      3: return lt | eq;
      4: return !(lt|eq); 5: return !eq;     6: return !lt;
      7: return 1'b1;     default: return 1'b0;
    endcase
  endfunction

  function automatic bit combf(int comb, bit x, bit p);
    case (comb)
      0: return x & p; 1: return x | p; 2: return x ^ p; default: return x;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] ep, bit ee);
    n_chk++;
    if (pred !== ep || err !== ee) begin
      n_bad++;
      $display("FAIL %s pred=%h err=%b expected pred=%h err=%b", tag, pred, err, ep, ee);
    end
  endtask

  task automatic run(string tag, int pri, int sec, int src, bit neg, int comb,
                     bit sgn, int cond, logic [31:0] a, logic [31:0] b, bit sel);
    logic [31:0] bb = sel ? b : regb;
    bit c, p;
    @(negedge clk);
    instr = mk(pri, sec, src, neg, comb, sgn, cond);
    opa = a; bsel = sel;
    if (sel) cbufb = b; else regb = b;
    bb = b;
    c = cmpf(cond, sgn, a, bb);
    p = ((src == 7) ? 1'b1 : e[src]) ^ neg;
    if (pri != 7) begin
      e[pri] = combf(comb, c, p);
      if (sec != 7) e[sec] = combf(comb, !c, p);
    end
    valid = 1'b1;
    @(posedge clk); #1;
    check(tag, {1'b1, e}, pri == 7);
    valid = 1'b0;
    if (sel) regb = ~b; else cbufb = ~b;
  endtask

  task automatic t_reset;
    check("R1", 8'h80, 1'b0);
  endtask

  task automatic t_unsigned;
    for (int cd = 1; cd <= 6; cd++) begin
      run("R2", 0, 1, 7, 0, 0, 0, cd, 32'h1, 32'hFFFF_FFFF, 0);
      run("R2", 2, 3, 7, 0, 0, 0, cd, 32'h55, 32'h55, 0);
      run("R2", 4, 5, 7, 0, 0, 0, cd, 32'h9000_0000, 32'h10, 0);
    end
  endtask

  task automatic t_signed;
    for (int cd = 1; cd <= 6; cd++) begin
      run("R3", 0, 1, 7, 0, 0, 1, cd, 32'h1, 32'hFFFF_FFFF, 0);
      run("R3", 2, 3, 7, 0, 0, 1, cd, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    end
  endtask

  task automatic t_comb;
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++) begin
        run("R5", 6, 7, 7, 0, 0, 0, s ? 7 : 0, 0, 0, 0);
        run("R4", 0, 1, 6, 0, k, 0, 1, 32'd3, 32'd9, 0);
        run("R6", 2, 3, 6, 0, k, 0, 1, 32'd9, 32'd3, 0);
      end
  endtask

  task automatic t_neg;
    run("R5", 5, 7, 7, 0, 0, 0, 7, 0, 0, 0);
    run("R5", 0, 1, 5, 1, 0, 0, 2, 32'd4, 32'd4, 0);
    run("R5", 2, 3, 5, 0, 0, 0, 2, 32'd4, 32'd4, 0);
    run("R5", 4, 6, 7, 1, 1, 0, 1, 32'd8, 32'd2, 0);
  endtask

  task automatic t_sec7;
    run("R7", 3, 7, 7, 0, 3, 0, 7, 0, 0, 0);
    run("R7", 0, 7, 7, 0, 3, 0, 0, 0, 0, 0);
    run("R7", 1, 2, 7, 0, 3, 0, 0, 0, 0, 0);
  endtask

  task automatic t_same;
    run("R8", 4, 4, 7, 0, 0, 0, 7, 0, 0, 0);
    run("R8", 4, 4, 7, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_illegal;
    run("R9", 7, 0, 7, 0, 1, 0, 7, 0, 0, 0);
    run("R9", 7, 7, 7, 0, 2, 0, 0, 0, 0, 0);
    run("R9", 0, 1, 7, 0, 0, 0, 7, 0, 0, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr = mk(0, 1, 7, 0, 2, 0, 7); opa = 1; regb = 2;
    repeat (3) begin
      @(posedge clk); #1;
      check("R10", {1'b1, e}, 1'b0);
    end
  endtask

  task automatic t_cbuf;
    regb = 32'd100;
    run("R11", 0, 1, 7, 0, 0, 0, 1, 32'd50, 32'd10, 1);
    run("R11", 2, 3, 7, 0, 0, 0, 1, 32'd50, 32'd100, 0);
    run("R11", 4, 5, 7, 0, 0, 1, 1, 32'd5, 32'hFFFF_FFF0, 1);
  endtask

  task automatic t_const;
    run("R12", 0, 1, 7, 0, 3, 0, 0, 32'd1, 32'd1, 0);
    run("R12", 2, 3, 7, 0, 3, 1, 7, 32'd1, 32'd0, 0);
    run("R12", 4, 5, 7, 0, 3, 0, 7, 32'hFFFF_FFFF, 32'd0, 1);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1; t_reset();
    t_unsigned();
    t_signed();
    t_comb();
    t_neg();
    t_sec7();
    t_same();
    t_illegal();
    t_idle();
    t_cbuf();
    t_const();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule